// File: doc/BRIEF.md
# LIN Master Frame Controller

This block runs one LIN frame in the master role. Software sets up the frame through a small register file that sits behind an indirect port. One strobe loads an address register, and a second strobe writes the register that address selects. Software loads a 6-bit frame identifier, a length code with a checksum-style flag, a direction bit and up to eight data bytes. It then writes the start bit. The block sends the header: a long dominant break, a recessive delimiter, the sync byte 0x55 and the identifier with its two parity bits added.

In the transmit direction it then sends the buffered data bytes and a checksum byte. In the receive direction it releases the line, collects the slave's bytes into the same buffer and compares the checksum the slave sends. The end of every frame, good or bad, sets a sticky done flag that drives the interrupt output, along with any error bits. The block times every bit from a one-pulse-per-bit `baud_tick` input. It contains no baud generator and no transceiver.

Top module: `lin_master_ctrl`

## Requirements
- R1: After reset, `lin_tx` is 1, `irq` is 0, the status register reads 0x00 and the control register reads 0x00.
- R2: A frame begins with BREAK_BITS (default 13) bit times of 0 on `lin_tx`, then one bit time of 1, then the byte 0x55, then the protected identifier. Every byte is sent as a 0 start bit, eight data bits least significant first, and a 1 stop bit. `lin_tx` changes only on a clock edge where `baud_tick` is 1.
- R3: The protected identifier is {P1, P0, id[5:0]}, where P0 (bit 6) = id0^id1^id2^id4 and P1 (bit 7) = NOT(id1^id3^id4^id5).
- R4: With control bit 5 set to 1 (transmit), the header is followed by buffer bytes 0x00, 0x01, … up to the frame length, in that order, and then one checksum byte.
- R5: The checksum is the bitwise inverse of the 8-bit sum with end-around carry. The classic form (size register bit 7 = 0) sums only the data bytes. The enhanced form (bit 7 = 1) also adds the protected identifier.
- R6: Size register bits [3:0] give the byte count 1–8. Code 15 derives the count from the identifier: identifiers 0–31 give 2 bytes, 32–47 give 4 bytes and 48–63 give 8 bytes. Code 0 counts as 1 and codes 9–14 count as 8.
- R7: At the end of every frame, status bit 0 (done) and `irq` go to 1. A write of any value to the status register (address 0x09) clears all status bits and `irq`. Control bit 0 reads 1 while a frame is in progress.
- R8: With control bit 5 set to 0 (receive), `lin_tx` stays 1 after the header. Each received byte is stored in the buffer in order. Status bit 1 is set when the received checksum byte differs from the computed one.
- R9: In receive, if TIMEOUT_BITS (default 40) consecutive bit times pass with no start bit, status bit 2 is set and the frame ends.
- R10: In receive, a received stop bit of 0 sets status bit 3 and ends the frame.
- R11: While a frame is in progress, writes to the buffer, control, size and identifier registers have no effect, and a further start request is ignored.
- R12: A pulse on `bus_addr_we` loads `bus_wdata[3:0]` into the address register. A pulse on `bus_data_we` writes the addressed register. `bus_rdata` shows the addressed register from the second clock after the address write. The register map is:

  | Address | Register | Field layout |
  |---|---|---|
  | 0x00–0x07 | data buffer | one byte each |
  | 0x08 | control | bit 5 direction, bit 0 start/busy |
  | 0x09 | status | bits 3..0 as in R7–R10 |
  | 0x0B | size | bit 7 enhanced, bits [3:0] code |
  | 0x0E | identifier | bits [5:0] |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr_we | input | 1 | Load the address register from `bus_wdata` |
| bus_data_we | input | 1 | Write `bus_wdata` to the addressed register |
| bus_wdata | input | 8 | Write data for both strobes |
| bus_rdata | output | 8 | Registered contents of the addressed register |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| lin_rx | input | 1 | Received line level |
| lin_tx | output | 1 | Transmitted line level (1 = recessive) |
| irq | output | 1 | Interrupt request, equal to the sticky done flag |

## Verification
The checker watches four things on every cycle:
- `lin_tx` moves only on a tick.
- The line stays recessive while the block is in the receive phase.
- A start is accepted only when the block is idle, and the byte index never passes the frame length plus two.
- An interrupt rises only once the sequencer is idle, and a status clear that no new event overlaps leaves `irq` low.

Other behaviours need the bench's scenarios:
- the exact bit stream of the header, data and checksum, compared each clock against a queued model across several identifiers, lengths and checksum styles;
- the derived lengths;
- the contents of the receive buffer;
- the separate checksum, timeout and stop-bit error bits;
- the rejection of writes made during a frame.

// File: rtl/lin_pkg.sv
package lin_pkg;
  localparam int BYTE_W = 8;
  localparam int NBUF   = 8;
  localparam logic [3:0] A_CTRL  = 4'h8;
  localparam logic [3:0] A_STAT  = 4'h9;
  localparam logic [3:0] A_SIZE  = 4'hB;
  localparam logic [3:0] A_IDENT = 4'hE;

  typedef enum logic [2:0] {S_IDLE, S_BRK, S_DELIM, S_TXB, S_RXW, S_RXB} seq_st_t;

  // identifier with both parity bits on top
  function automatic logic [7:0] pid_of(input logic [5:0] id);
    pid_of = {~(id[1] ^ id[3] ^ id[4] ^ id[5]), id[0] ^ id[1] ^ id[2] ^ id[4], id};
  endfunction

  // one step of the ones'-complement style running sum
  function automatic logic [7:0] sum_ec(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    sum_ec = t[7:0] + {7'd0, t[8]};
  endfunction

  function automatic logic [3:0] len_of(input logic [3:0] code, input logic [5:0] id);
    if (code == 4'hF)      len_of = id[5] ? (id[4] ? 4'd8 : 4'd4) : 4'd2;
    else if (code == 4'h0) len_of = 4'd1;
    else if (code > 4'd8)  len_of = 4'd8;
    else                   len_of = code;
  endfunction
endpackage

// File: rtl/lin_regfile.sv
module lin_regfile
  import lin_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int DEPTH = NBUF,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          busy,
  input  logic          evt_done,
  input  logic          evt_csum,
  input  logic          evt_tmo,
  input  logic          evt_stop,
  input  logic          rx_we,
  input  logic [IW-1:0] rx_idx,
  input  logic [DW-1:0] rx_byte,
  input  logic [IW-1:0] buf_ridx,
  output logic [DW-1:0] buf_rbyte,
  output logic [5:0]    id_o,
  output logic [3:0]    code_o,
  output logic          enh_o,
  output logic          dir_o,
  output logic          start_o,
  output logic          sts_clr,
  output logic          irq
);
  logic [3:0]    addr_q;
  logic [DW-1:0] dbuf [DEPTH];
  logic [3:0]    sts_q, sts_nx;
  logic          cfg_wr;

  assign cfg_wr  = data_we && !busy;
  assign sts_clr = data_we && (addr_q == A_STAT);
  assign irq     = sts_q[0];
  assign buf_rbyte = dbuf[buf_ridx];

  always_comb begin
    sts_nx = sts_clr ? 4'h0 : sts_q;
    if (evt_done) sts_nx = sts_nx | {evt_stop, evt_tmo, evt_csum, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      id_o    <= '0;
      code_o  <= '0;
      enh_o   <= 1'b0;
      dir_o   <= 1'b0;
      start_o <= 1'b0;
      sts_q   <= '0;
    end else begin
      sts_q   <= sts_nx;
      start_o <= cfg_wr && (addr_q == A_CTRL) && wdata[0];
      if (addr_we) addr_q <= wdata[3:0];
      if (cfg_wr) begin
        case (addr_q)
          A_CTRL:  dir_o <= wdata[5];
          A_SIZE:  begin code_o <= wdata[3:0]; enh_o <= wdata[7]; end
          A_IDENT: id_o <= wdata[5:0];
          default: ;
        endcase
      end
    end
  end

  // buffer: no reset so it maps onto distributed or block memory
  always_ff @(posedge clk) begin
    if (rx_we) dbuf[rx_idx] <= rx_byte;
    else if (cfg_wr && !addr_q[3]) dbuf[addr_q[IW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (!addr_q[3]) rdata <= dbuf[addr_q[IW-1:0]];
    else begin
      case (addr_q)
        A_CTRL:  rdata <= {2'b00, dir_o, 4'b0000, busy};
        A_STAT:  rdata <= {4'b0000, sts_q};
        A_SIZE:  rdata <= {enh_o, 3'b000, code_o};
        A_IDENT: rdata <= {2'b00, id_o};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lin_frame_seq.sv
module lin_frame_seq
  import lin_pkg::*;
#(
  parameter int BREAK_BITS   = 13,
  parameter int TIMEOUT_BITS = 40,
  localparam int CNT_W = $clog2((BREAK_BITS > 10 ? BREAK_BITS : 10) + 1),
  localparam int TMO_W = $clog2(TIMEOUT_BITS) + 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rx_in,
  input  logic       start,
  input  logic       dir,
  input  logic       enh,
  input  logic [5:0] id,
  input  logic [3:0] code,
  input  logic [7:0] buf_rbyte,
  output logic [2:0] buf_ridx,
  output logic       tx_out,
  output logic       busy,
  output logic       rx_phase,
  output logic       rx_we,
  output logic [2:0] rx_idx,
  output logic [7:0] rx_byte,
  output logic       evt_done,
  output logic       evt_csum,
  output logic       evt_tmo,
  output logic       evt_stop,
  output logic [3:0] frame_len,
  output logic [3:0] byte_idx
);
  seq_st_t    st;
  logic [CNT_W-1:0] cnt;
  logic [TMO_W-1:0] tmo;
  logic [3:0] idx, len;
  logic [7:0] pid, sum;
  logic [9:0] shr;
  logic       dir_l, enh_l;

  assign busy      = (st != S_IDLE);
  assign rx_phase  = (st == S_RXW) || (st == S_RXB);
  assign buf_ridx  = idx[2:0] - 3'd1;
  assign frame_len = len;
  assign byte_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cnt <= '0; tmo <= '0; idx <= '0; len <= '0;
      pid <= '0; sum <= '0; shr <= '1; dir_l <= 1'b0; enh_l <= 1'b0;
      tx_out <= 1'b1; rx_we <= 1'b0; rx_idx <= '0; rx_byte <= '0;
      evt_done <= 1'b0; evt_csum <= 1'b0; evt_tmo <= 1'b0; evt_stop <= 1'b0;
    end else begin
      rx_we <= 1'b0; evt_done <= 1'b0; evt_csum <= 1'b0;
      evt_tmo <= 1'b0; evt_stop <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st <= S_BRK; cnt <= '0; idx <= '0;
          len <= len_of(code, id); pid <= pid_of(id);
          dir_l <= dir; enh_l <= enh;
        end
      end else if (tick) begin
        case (st)
          S_BRK: begin
            tx_out <= 1'b0;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(BREAK_BITS - 1)) st <= S_DELIM;
          end
          S_DELIM: begin
            tx_out <= 1'b1;
            shr <= {1'b1, 8'h55, 1'b0};
            cnt <= '0;
            st <= S_TXB;
          end
          S_TXB: begin
            tx_out <= shr[0];
            shr <= {1'b1, shr[9:1]};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(9)) begin
              cnt <= '0;
              idx <= idx + 4'd1;
              if (idx == 4'd0) shr <= {1'b1, pid, 1'b0};
              else if (idx == 4'd1 && !dir_l) begin
                st <= S_RXW; tmo <= '0; sum <= enh_l ? pid : 8'h00;
              end else if (idx == 4'd1) begin
                shr <= {1'b1, buf_rbyte, 1'b0};
                sum <= sum_ec(enh_l ? pid : 8'h00, buf_rbyte);
              end else if (idx <= len) begin
                shr <= {1'b1, buf_rbyte, 1'b0};
                sum <= sum_ec(sum, buf_rbyte);
              end else if (idx == len + 4'd1) shr <= {1'b1, ~sum, 1'b0};
              else begin
                st <= S_IDLE; evt_done <= 1'b1;
              end
            end
          end
          S_RXW: begin
            if (!rx_in) begin
              st <= S_RXB; cnt <= '0;
            end else begin
              tmo <= tmo + 1'b1;
              if (tmo == TMO_W'(TIMEOUT_BITS - 1)) begin
                st <= S_IDLE; evt_done <= 1'b1; evt_tmo <= 1'b1;
              end
            end
          end
          S_RXB: begin
            cnt <= cnt + 1'b1;
            if (cnt != CNT_W'(8)) shr[7:0] <= {rx_in, shr[7:1]};
            else begin
              cnt <= '0;
              if (!rx_in) begin
                st <= S_IDLE; evt_done <= 1'b1; evt_stop <= 1'b1;
              end else if (idx <= len + 4'd1) begin
                rx_we <= 1'b1; rx_idx <= idx[2:0] - 3'd2; rx_byte <= shr[7:0];
                sum <= sum_ec(sum, shr[7:0]);
                idx <= idx + 4'd1; st <= S_RXW; tmo <= '0;
              end else begin
                st <= S_IDLE; evt_done <= 1'b1;
                evt_csum <= (shr[7:0] != ~sum);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_master_ctrl.sv
module lin_master_ctrl
  import lin_pkg::*;
#(
  parameter int BREAK_BITS   = 13,
  parameter int TIMEOUT_BITS = 40
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_addr_we,
  input  logic       bus_data_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  input  logic       lin_rx,
  output logic       lin_tx,
  output logic       irq
);
  logic       busy, rx_phase, start_go, sts_clr;
  logic       evt_done, evt_csum, evt_tmo, evt_stop;
  logic       rx_we, enh, dir;
  logic [2:0] rx_idx, buf_ridx;
  logic [7:0] rx_byte, buf_rbyte;
  logic [5:0] id;
  logic [3:0] code, frame_len, byte_idx;

  lin_regfile #(.DW(BYTE_W), .DEPTH(NBUF)) u_regs (
    .clk(clk), .rst(rst), .addr_we(bus_addr_we), .data_we(bus_data_we),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(busy),
    .evt_done(evt_done), .evt_csum(evt_csum), .evt_tmo(evt_tmo), .evt_stop(evt_stop),
    .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .buf_ridx(buf_ridx), .buf_rbyte(buf_rbyte),
    .id_o(id), .code_o(code), .enh_o(enh), .dir_o(dir),
    .start_o(start_go), .sts_clr(sts_clr), .irq(irq)
  );

  lin_frame_seq #(.BREAK_BITS(BREAK_BITS), .TIMEOUT_BITS(TIMEOUT_BITS)) u_seq (
    .clk(clk), .rst(rst), .tick(baud_tick), .rx_in(lin_rx), .start(start_go),
    .dir(dir), .enh(enh), .id(id), .code(code),
    .buf_rbyte(buf_rbyte), .buf_ridx(buf_ridx), .tx_out(lin_tx),
    .busy(busy), .rx_phase(rx_phase), .rx_we(rx_we), .rx_idx(rx_idx), .rx_byte(rx_byte),
    .evt_done(evt_done), .evt_csum(evt_csum), .evt_tmo(evt_tmo), .evt_stop(evt_stop),
    .frame_len(frame_len), .byte_idx(byte_idx)
  );
endmodule

// File: rtl/lin_master_chk.sv
module lin_master_chk (
  input logic       clk,
  input logic       rst,
  input logic       baud_tick,
  input logic       lin_tx,
  input logic       irq,
  input logic       busy,
  input logic       start_go,
  input logic       rx_phase,
  input logic       evt_done,
  input logic       sts_clr,
  input logic [3:0] frame_len,
  input logic [3:0] byte_idx
);
  // R2: line moves only on a bit tick
  assert_tx_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(baud_tick) |-> $stable(lin_tx));

  // R8: line released during the receive phase
  assert_rx_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    rx_phase |-> lin_tx);

  // R11: a start request only reaches an idle sequencer
  assert_start_idle_R11: assert property (@(posedge clk) disable iff (rst)
    start_go |-> !busy);

  // R7: the interrupt rises only once the frame has ended
  assert_irq_after_frame_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !busy);

  // R7: a clear with no concurrent event drops the interrupt
  assert_clear_drops_irq_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(sts_clr) && !$past(evt_done)) |-> !irq);

  // R6: byte position stays within length plus sync/identifier/checksum
  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (byte_idx <= frame_len + 4'd2));
endmodule

bind lin_master_ctrl lin_master_chk u_lin_chk (
  .clk(clk), .rst(rst), .baud_tick(baud_tick), .lin_tx(lin_tx), .irq(irq),
  .busy(busy), .start_go(start_go), .rx_phase(rx_phase), .evt_done(evt_done),
  .sts_clr(sts_clr), .frame_len(frame_len), .byte_idx(byte_idx)
);

// File: tb/test_lin_master_ctrl.sv
module test_lin_master_ctrl;
  localparam int BRK = 13;
  localparam int HDR_TICKS = BRK + 1 + 20;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_addr_we = 1'b0, bus_data_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  wire  [7:0] bus_rdata;
  logic baud_tick = 1'b0, lin_rx = 1'b1;
  wire  lin_tx, irq;

  int checks = 0, fails = 0;
  int tdiv = 0;
  bit tx_q[$];
  logic exp_tx = 1'b1;
  logic [7:0] dat [8];
  logic [7:0] rv;

  lin_master_ctrl i_lin_master_ctrl (
    .clk(clk), .rst(rst), .bus_addr_we(bus_addr_we), .bus_data_we(bus_data_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
    .lin_rx(lin_rx), .lin_tx(lin_tx), .irq(irq)
  );

  always #10 clk = ~clk;

  // bit-rate pulse, one clock in eight
  always @(negedge clk) begin
    tdiv <= (tdiv == 7) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 6);
  end

  // reference line model: one queued bit per tick
  always @(posedge clk) begin
    if (rst) exp_tx <= 1'b1;
    else if (baud_tick && tx_q.size() > 0) exp_tx <= tx_q.pop_front();
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (lin_tx !== exp_tx) begin
        fails++;
        $display("FAIL R2/R3/R4/R5 lin_tx stream actual=%b expected=%b t=%0t", lin_tx, exp_tx, $time);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog actual=no frame end expected=irq");
    finish_run();
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pid(input logic [5:0] id);
    bit p0, p1;
    p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
    p1 = !(id[1] ^ id[3] ^ id[4] ^ id[5]);
    return {p1, p0, id};
  endfunction

  function automatic int ref_len(input logic [3:0] code, input logic [5:0] id);
    if (code == 4'd15) return (id < 32) ? 2 : (id < 48) ? 4 : 8;
    if (code == 4'd0) return 1;
    if (code > 4'd8) return 8;
    return int'(code);
  endfunction

  function automatic logic [7:0] ref_csum(input int seed, input logic [7:0] d [8], input int n);
    int s = seed;
    for (int i = 0; i < n; i++) begin
      s = s + d[i];
      if (s > 255) s = s - 255;
    end
    return ~s[7:0];
  endfunction

  task automatic wait_tick();
    do @(posedge clk); while (!baud_tick);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); bus_addr_we = 1'b1; bus_wdata = a;
    @(negedge clk); bus_addr_we = 1'b0; bus_data_we = 1'b1; bus_wdata = v;
    @(negedge clk); bus_data_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr_we = 1'b1; bus_wdata = a;
    @(negedge clk); bus_addr_we = 1'b0;
    @(negedge clk);
    @(negedge clk); v = bus_rdata;
  endtask

  task automatic push_byte(input logic [7:0] b);
    tx_q.push_back(1'b0);
    for (int i = 0; i < 8; i++) tx_q.push_back(b[i]);
    tx_q.push_back(1'b1);
  endtask

  task automatic start_frame(input logic [5:0] id, input logic [3:0] code,
                             input bit enh, input bit dir);
    int n;
    logic [7:0] pid;
    wr(8'h0E, {2'b00, id});
    wr(8'h0B, {enh, 3'b000, code});
    for (int i = 0; i < 8; i++) wr(8'(i), dat[i]);
    n = ref_len(code, id);
    pid = ref_pid(id);
    @(negedge clk); bus_addr_we = 1'b1; bus_wdata = 8'h08;
    @(negedge clk); bus_addr_we = 1'b0;
    wait_tick();
    @(negedge clk);
    bus_data_we = 1'b1; bus_wdata = {2'b00, dir, 5'b00001};
    for (int i = 0; i < BRK; i++) tx_q.push_back(1'b0);
    tx_q.push_back(1'b1);
    push_byte(8'h55);
    push_byte(pid);
    if (dir) begin
      for (int i = 0; i < n; i++) push_byte(dat[i]);
      push_byte(ref_csum(enh ? int'(pid) : 0, dat, n));
    end
    @(negedge clk); bus_data_we = 1'b0;
  endtask

  task automatic wait_done();
    while (!irq) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); lin_rx = b;
    wait_tick();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stopb);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    send_bit(stopb);
  endtask

  task automatic clear_status();
    wr(8'h09, 8'h00);
    chk("R7 irq after status clear", irq, 0);
    rd(8'h09, rv); chk("R7 status after clear", rv, 8'h00);
  endtask

  initial begin
    logic [7:0] cs;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk("R1 lin_tx idle", lin_tx, 1);
    chk("R1 irq low", irq, 0);
    rd(8'h09, rv); chk("R1 status", rv, 8'h00);
    rd(8'h08, rv); chk("R1 control", rv, 8'h00);
    // indirect register access
    wr(8'h0E, 8'h2A); rd(8'h0E, rv); chk("R12 identifier readback", rv, 8'h2A);
    wr(8'h0B, 8'h85); rd(8'h0B, rv); chk("R12 size readback", rv, 8'h85);

    // transmit, classic, 8 bytes
    for (int i = 0; i < 8; i++) dat[i] = 8'h41 + 8'(i);
    start_frame(6'h11, 4'd8, 1'b0, 1'b1);
    rd(8'h08, rv); chk("R7 busy bit during frame", rv, 8'h21);
    wait_done();
    repeat (20) @(negedge clk);
    chk("R4 model queue drained", tx_q.size(), 0);
    rd(8'h09, rv); chk("R7 done status", rv, 8'h01);
    clear_status();

    // transmit, enhanced, 3 bytes
    dat = '{8'hFF, 8'hFE, 8'h80, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    start_frame(6'h3C, 4'd3, 1'b1, 1'b1);
    wait_done();
    repeat (20) @(negedge clk);
    chk("R5 enhanced frame drained", tx_q.size(), 0);
    clear_status();

    // transmit, derived length (id 0x25 -> 4), writes during frame
    dat = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h60, 8'h70, 8'h80};
    start_frame(6'h25, 4'hF, 1'b0, 1'b1);
    repeat (100) @(negedge clk);
    wr(8'h00, 8'hEE);
    wr(8'h0E, 8'h01);
    wr(8'h08, 8'h01);
    wait_done();
    repeat (20) @(negedge clk);
    chk("R6 derived length 4 drained", tx_q.size(), 0);
    rd(8'h00, rv); chk("R11 buffer write ignored", rv, 8'h10);
    rd(8'h0E, rv); chk("R11 identifier write ignored", rv, 8'h25);
    clear_status();

    // transmit, length code 0 counts as 1
    start_frame(6'h00, 4'd0, 1'b0, 1'b1);
    wait_done();
    repeat (20) @(negedge clk);
    chk("R6 code zero drained", tx_q.size(), 0);
    clear_status();

    // receive, classic, derived length (id 0x0A -> 2), good checksum
    dat = '{default: 8'h00};
    start_frame(6'h0A, 4'hF, 1'b0, 1'b0);
    repeat (HDR_TICKS) wait_tick();
    send_bit(1'b1);
    dat[0] = 8'h12; dat[1] = 8'hF0;
    send_byte(8'h12, 1'b1);
    send_byte(8'hF0, 1'b1);
    send_byte(ref_csum(0, dat, 2), 1'b1);
    @(negedge clk); lin_rx = 1'b1;
    wait_done();
    rd(8'h09, rv); chk("R8 receive good status", rv, 8'h01);
    rd(8'h00, rv); chk("R8 received byte 0", rv, 8'h12);
    rd(8'h01, rv); chk("R8 received byte 1", rv, 8'hF0);
    clear_status();

    // receive, enhanced, bad checksum
    dat = '{8'h80, 8'h90, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
    cs = ref_csum(int'(ref_pid(6'h21)), dat, 2) ^ 8'h01;
    start_frame(6'h21, 4'd2, 1'b1, 1'b0);
    repeat (HDR_TICKS) wait_tick();
    send_byte(8'h80, 1'b1);
    send_byte(8'h90, 1'b1);
    send_byte(cs, 1'b1);
    @(negedge clk); lin_rx = 1'b1;
    wait_done();
    rd(8'h09, rv); chk("R8 checksum mismatch status", rv, 8'h03);
    clear_status();

    // receive, enhanced, good checksum
    cs = ref_csum(int'(ref_pid(6'h21)), dat, 2);
    start_frame(6'h21, 4'd2, 1'b1, 1'b0);
    repeat (HDR_TICKS) wait_tick();
    send_byte(8'h80, 1'b1);
    send_byte(8'h90, 1'b1);
    send_byte(cs, 1'b1);
    @(negedge clk); lin_rx = 1'b1;
    wait_done();
    rd(8'h09, rv); chk("R5 enhanced receive checksum accepted", rv, 8'h01);
    clear_status();

    // receive timeout: no slave answer
    start_frame(6'h05, 4'd1, 1'b0, 1'b0);
    wait_done();
    rd(8'h09, rv); chk("R9 timeout status", rv, 8'h05);
    clear_status();

    // receive with a bad stop bit
    start_frame(6'h07, 4'd1, 1'b0, 1'b0);
    repeat (HDR_TICKS) wait_tick();
    send_byte(8'h5A, 1'b0);
    @(negedge clk); lin_rx = 1'b1;
    wait_done();
    rd(8'h09, rv); chk("R10 stop bit error status", rv, 8'h09);
    clear_status();
    chk("R1 line idle at end", lin_tx, 1);

    finish_run();
  end
endmodule